// File: doc/BRIEF.md
# Strobed Four-Beat Burst Address Generator

This block sits in front of a synchronous memory and produces the address for each access. A full external address is captured when either of two active-low address strobes is sampled asserted on a rising clock edge. One strobe serves a processor and the other a cache controller. After that load, the two least significant address bits step through a four-beat burst under an active-low advance input. The upper bits stay fixed for the whole burst.

The beat order is chosen at load time by an order-select input. Low selects linear order (start plus beat count, modulo four). High selects interleaved order (start XOR beat count). High is the resting, default choice. The processor strobe only counts while its active-low chip-enable qualifier is asserted. The controller strobe loads regardless of that qualifier. A load may happen on every cycle, so bursts are optional. An output flag tells the downstream logic whether the current address comes from a fresh load or from a continued beat.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, `addr_q` is all zeros and `first_q` is 0.
- R2: A rising edge with `ctl_strb_n` low loads `addr_in` whatever the value of `cpu_ce_n`. After that edge `addr_q` equals the sampled `addr_in` and `first_q` is 1.
- R3: A rising edge with `cpu_strb_n` low and `cpu_ce_n` low loads `addr_in` the same way. This load has priority over the controller strobe; both strobes load the same address.
- R4: When `cpu_strb_n` is low, `cpu_ce_n` is high and `ctl_strb_n` is high, the processor strobe is ignored. With `adv_n` high, `addr_q` and `first_q` keep their values.
- R5: A rising edge with no load and `adv_n` low advances the beat count by one and clears `first_q` to 0.
- R6: If `order_sel` was 0 at the load edge, the low two bits of `addr_q` equal (start + beat) mod 4, where start is bits 1:0 of the loaded address.
- R7: If `order_sel` was 1 at the load edge, the low two bits of `addr_q` equal start XOR beat.
- R8: Bits above bit 1 of `addr_q` never change on an advance. After four advances the low bits return to the start value, with no carry into bit 2.
- R9: A rising edge with no load and `adv_n` high holds `addr_q` and `first_q` unchanged.
- R10: A load takes priority over an advance on the same edge. Loads on consecutive edges each take effect with no lost cycle.
- R11: A change of `order_sel` between loads has no effect on the order of the burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | External address, sampled on a load |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| cpu_ce_n | input | 1 | Chip-enable qualifier for the processor strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_q | output | ADDR_W | Current access address |
| first_q | output | 1 | 1 on the first beat after a load, 0 on continued beats |

## Verification
All state is visible at the ports one edge after it is written. A wrong beat count, start value or latched order therefore shows in the low bits of `addr_q` on the very next cycle. A fault in the upper-address register or in the load decode shows on the cycle after the offending strobe edge, as a wrong address or as a wrong `first_q`. The bench compares every cycle against a model. Long advance runs expose wrap faults within four beats, and mid-burst order flips expose an order that was not latched.

// File: rtl/burst_addr_pkg.sv
// Package: shared types and the beat-order mapping for the burst address
// generator. Assumes a fixed four-beat burst on two low address bits.
package burst_addr_pkg;

    localparam int LOW_W = 2;
    localparam int BEATS = 1 << LOW_W;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef logic [LOW_W-1:0] low_t;

endpackage

// File: rtl/burst_load_ctrl.sv
// Module: burst_load_ctrl
// Decodes the two address strobes, the processor chip-enable qualifier and
// the advance input into one load request and one step request.
// Assumes all inputs are already synchronous to clk; purely combinational.
module burst_load_ctrl (
    input  logic cpu_strb_n,
    input  logic ctl_strb_n,
    input  logic cpu_ce_n,
    input  logic adv_n,
    output logic load_en,
    output logic cpu_load,
    output logic step_en
);

    logic cpu_req;
    logic ctl_req;

    // Qualify each strobe; the processor strobe needs chip enable.
    always_comb begin
        cpu_req = !cpu_strb_n && !cpu_ce_n;
        ctl_req = !ctl_strb_n;
    end

    // Priority: processor load first, then controller load, then advance.
    always_comb begin
        cpu_load = 1'b0;
        load_en  = 1'b0;
        step_en  = 1'b0;
        if (cpu_req) begin
            cpu_load = 1'b1;
            load_en  = 1'b1;
        end else if (ctl_req) begin
            load_en  = 1'b1;
        end else if (!adv_n) begin
            step_en  = 1'b1;
        end
    end

endmodule

// File: rtl/burst_beat_counter.sv
// Module: burst_beat_counter
// Holds the start value of the low bits, the beat count, the latched order
// and the first-beat flag. A load presets the start and clears the count; a
// step increments the count, which wraps naturally at four beats.
// Assumes load_en and step_en are never both high (decoder guarantees it).
module burst_beat_counter
    import burst_addr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_en,
    input  logic   step_en,
    input  low_t   start_in,
    input  order_e order_in,
    output low_t   start_q,
    output low_t   beat_q,
    output order_e order_q,
    output logic   first_q
);

    // Start value and order are captured only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (load_en) begin
            start_q <= start_in;
            order_q <= order_in;
        end
    end

    // Beat count: cleared on load, incremented on step, else held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_en) begin
            beat_q <= '0;
        end else if (step_en) begin
            beat_q <= beat_q + low_t'(1);
        end
    end

    // First-beat flag: set by a load, cleared by a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else if (load_en) begin
            first_q <= 1'b1;
        end else if (step_en) begin
            first_q <= 1'b0;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps start value and beat count to the low address bits. Linear order
// adds with wrap; interleaved order XORs. Both variants are built bit by
// bit in a generate loop and the latched order picks one.
// Assumes LOW_W from the package; purely combinational.
module burst_order_map
    import burst_addr_pkg::*;
(
    input  low_t   start_q,
    input  low_t   beat_q,
    input  order_e order_q,
    output low_t   low_out
);

    low_t lin_bits;
    low_t ilv_bits;
    logic [LOW_W:0] carry;

    assign carry[0] = 1'b0;

    // One ripple adder stage and one XOR stage per low address bit.
    for (genvar i = 0; i < LOW_W; i++) begin : g_bit
        assign lin_bits[i]  = start_q[i] ^ beat_q[i] ^ carry[i];
        assign carry[i+1]   = (start_q[i] & beat_q[i]) |
                              (carry[i] & (start_q[i] ^ beat_q[i]));
        assign ilv_bits[i]  = start_q[i] ^ beat_q[i];
    end

    // Select the variant fixed at load time.
    always_comb begin
        low_out = (order_q == ORD_LINEAR) ? lin_bits : ilv_bits;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Captures a full address on either strobe and then walks the two low bits
// through a four-beat burst in linear or interleaved order. The upper bits
// are held in a register that changes only on a load.
// Assumes synchronous inputs and ADDR_W greater than LOW_W.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              cpu_ce_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_q,
    output logic              first_q
);

    localparam int HI_W = ADDR_W - LOW_W;

    logic            load_en;
    logic            cpu_load;
    logic            step_en;
    logic [HI_W-1:0] hi_q;
    low_t            start_q;
    low_t            beat_q;
    order_e          order_q;
    low_t            low_bits;
    order_e          order_in;

    assign order_in = order_e'(order_sel);

    burst_load_ctrl u_ctrl (
        .cpu_strb_n (cpu_strb_n),
        .ctl_strb_n (ctl_strb_n),
        .cpu_ce_n   (cpu_ce_n),
        .adv_n      (adv_n),
        .load_en    (load_en),
        .cpu_load   (cpu_load),
        .step_en    (step_en)
    );

    burst_beat_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .step_en  (step_en),
        .start_in (addr_in[LOW_W-1:0]),
        .order_in (order_in),
        .start_q  (start_q),
        .beat_q   (beat_q),
        .order_q  (order_q),
        .first_q  (first_q)
    );

    burst_order_map u_map (
        .start_q (start_q),
        .beat_q  (beat_q),
        .order_q (order_q),
        .low_out (low_bits)
    );

    // Upper address bits: loaded with the strobe, fixed during a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (load_en) begin
            hi_q <= addr_in[ADDR_W-1:LOW_W];
        end
    end

    // Current address: fixed upper part joined to the mapped low bits.
    always_comb begin
        addr_q = {hi_q, low_bits};
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Port-level temporal properties for burst_addr_gen, bound to every
// instance. Assumes the same ADDR_W as the bound instance.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              cpu_strb_n,
    input logic              ctl_strb_n,
    input logic              cpu_ce_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_q,
    input logic              first_q
);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (addr_q == '0) && !first_q);

    p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_strb_n |=> first_q && (addr_q == $past(addr_in)));

    p_cpu_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strb_n && !cpu_ce_n) |=> first_q && (addr_q == $past(addr_in)));

    p_cpu_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strb_n && cpu_ce_n && ctl_strb_n && adv_n)
        |=> $stable(addr_q) && $stable(first_q));

    p_step_clears_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_strb_n && (cpu_strb_n || cpu_ce_n) && !adv_n) |=> !first_q);

    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_strb_n && (cpu_strb_n || cpu_ce_n) && !adv_n)
        |=> $stable(addr_q[ADDR_W-1:2]));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_strb_n && (cpu_strb_n || cpu_ce_n) && adv_n)
        |=> $stable(addr_q) && $stable(first_q));

    p_load_over_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_strb_n && !adv_n) |=> first_q);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .cpu_strb_n (cpu_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .cpu_ce_n   (cpu_ce_n),
    .adv_n      (adv_n),
    .addr_q     (addr_q),
    .first_q    (first_q)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          cpu_strb_n = 1'b1;
    logic          ctl_strb_n = 1'b1;
    logic          cpu_ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_q;
    logic          first_q;

    int tests = 0;
    int fails = 0;

    // Reference model state
    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat = '0;
    logic          m_ord = 1'b1;
    logic          m_first = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
        .cpu_ce_n(cpu_ce_n), .adv_n(adv_n), .order_sel(order_sel),
        .addr_q(addr_q), .first_q(first_q)
    );

    function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] b, logic o);
        return o ? (s ^ b) : 2'(s + b);
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        return {m_hi, exp_low(m_start, m_beat, m_ord)};
    endfunction

    task automatic check(string req);
        tests++;
        if (addr_q !== exp_addr() || first_q !== m_first) begin
            fails++;
            $display("FAIL %s: addr=%h first=%b expected addr=%h first=%b",
                     req, addr_q, first_q, exp_addr(), m_first);
        end
    endtask

    // Drive one cycle at the falling edge, update the model at the rising
    // edge, compare at the next falling edge.
    task automatic cyc(logic cs, logic ts, logic ce, logic av, logic od,
                       logic [AW-1:0] a, string req);
        cpu_strb_n = cs; ctl_strb_n = ts; cpu_ce_n = ce;
        adv_n = av; order_sel = od; addr_in = a;
        @(posedge clk);
        if ((!cs && !ce) || !ts) begin
            m_hi = a[AW-1:2]; m_start = a[1:0]; m_beat = '0;
            m_ord = od; m_first = 1'b1;
        end else if (!av) begin
            m_beat = m_beat + 2'd1; m_first = 1'b0;
        end
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #1_600_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        // R2: controller strobe with chip enable high
        cyc(1, 0, 1, 1, 1, 20'hABCD2, "R2 ctl load ce high");
        // R7: interleaved from start 2
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 1, '0, "R7 interleaved step");
        // R8: wrapped back to start after four beats
        tests++;
        if (addr_q !== 20'hABCD2) begin
            fails++;
            $display("FAIL R8: addr=%h expected=%h", addr_q, 20'hABCD2);
        end
        // R3: processor strobe with chip enable low, linear from 3
        cyc(0, 1, 0, 1, 0, 20'h0FFF3, "R3 cpu load");
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 0, '0, "R6 R8 linear wrap no carry");
        // R4: processor strobe ignored without chip enable
        cyc(1, 1, 1, 0, 0, '0, "R5 step");
        cyc(0, 1, 1, 1, 0, 20'h12345, "R4 cpu strobe ignored");
        // R9: hold
        cyc(1, 1, 1, 1, 1, 20'h55555, "R9 hold");
        // R10: load wins over advance, back-to-back loads
        cyc(1, 0, 1, 0, 1, 20'h11111, "R10 load beats advance");
        cyc(0, 1, 0, 0, 0, 20'h22222, "R10 back-to-back load");
        cyc(0, 0, 0, 1, 1, 20'h33331, "R3 both strobes");
        // R11: order change mid burst has no effect
        cyc(1, 1, 1, 0, 0, '0, "R11 order flip mid burst");
        cyc(1, 1, 1, 0, 1, '0, "R11 order flip mid burst");
        cyc(1, 1, 1, 0, 0, '0, "R11 order flip mid burst");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic cs, ts, ce, av, od;
            cs = ($urandom_range(0, 9) < 2) ? 1'b0 : 1'b1;
            ts = ($urandom_range(0, 9) < 2) ? 1'b0 : 1'b1;
            ce = $urandom_range(0, 1) == 0;
            av = ($urandom_range(0, 9) < 6) ? 1'b0 : 1'b1;
            od = $urandom_range(0, 1) == 1;
            cyc(cs, ts, ce, av, od, AW'($urandom),
                "R2 R3 R4 R5 R6 R7 R9 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule